// File: doc/BRIEF.md
# Burst-Splitting Write Adapter

This block turns internal write requests into AXI4 write transactions. A client gives a start address and a beat count on a request handshake. The payload words arrive separately, in order, on a valid/ready stream. The adapter cuts each request into INCR bursts that are no longer than a configured maximum and never run past a 4 KB address page. It issues the address phase of each burst and drives the matching data beats. It then waits for one write response per burst.

The payload is held in a local buffer of `MAX_OUTST * MAX_BURST` words. An address phase is held back while `MAX_OUTST` bursts still lack a response. A build-time switch selects between two ways of issuing the address phase. In the eager way, the address phase may go out before any payload has arrived. In the safe way, the address phase waits until every beat of that burst sits in the buffer. The safe way can add latency. In return, the adapter never holds an open address phase on an interconnect while its data is stuck behind other traffic.

Only one request is in flight at a time. When every burst of the request has its response, the adapter emits a one-cycle completion pulse with an error flag.

Top module: `wr_burst_adapter`

## Requirements
- R1: While reset is asserted, `m_awvalid`, `m_wvalid` and `done_valid` are low, and `req_ready` and `in_ready` are high.
- R2: A request is split into bursts of at most `MAX_BURST` beats. `m_awlen` is the burst's beat count minus one, `m_awburst` is 2'b01 (INCR), and `m_awsize` is log2 of the bytes per word. Each burst starts at the byte address that follows the end of the previous burst.
- R3: No burst crosses a 4096-byte address boundary. A burst that would cross one ends at the boundary, and the next burst starts there.
- R4: Payload words leave on W in the order they were accepted on the input stream. Bursts take their beats in the order their address phases were accepted. `m_wlast` is high on the final beat of each burst and low on every other beat.
- R5: No more than `MAX_OUTST` bursts are ever accepted on AW without a matching B response. While that many are open, `m_awvalid` stays low.
- R6: With `CONSERVATIVE=1`, `m_awvalid` for a burst rises only once the buffer holds all of that burst's beats, not counting beats already claimed by earlier bursts.
- R7: With `CONSERVATIVE=0`, the address phase of a burst is issued even when no payload has arrived.
- R8: `req_ready` is low from the cycle after a request is accepted until `done_valid` pulses. `done_valid` pulses exactly once per request, after the last B response of that request.
- R9: `done_err` is high with `done_valid` if any burst of that request got a `m_bresp` other than 2'b00. Otherwise it is low. The flag does not carry over to the next request.
- R10: Once `m_awvalid` or `m_wvalid` is high, it stays high with a stable payload until the handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Adapter can take a request |
| req_addr | input | ADDR_W | Word-aligned start byte address |
| req_beats | input | LEN_W | Number of words in the request (at least 1) |
| in_valid | input | 1 | Payload word offered |
| in_ready | output | 1 | Buffer has room |
| in_data | input | DATA_W | Payload word |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Some burst of the completed request got an error response |
| m_awvalid | output | 1 | AW valid |
| m_awready | input | 1 | AW ready |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Log2 bytes per beat |
| m_awburst | output | 2 | Burst type, INCR |
| m_wvalid | output | 1 | W valid |
| m_wready | input | 1 | W ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes, all ones |
| m_wlast | output | 1 | Final beat of a burst |
| m_bvalid | input | 1 | B valid |
| m_bready | output | 1 | B ready, tied high |
| m_bresp | input | 2 | Write response code |

## Verification
The assertions take for granted that the downstream side behaves as an AXI4 subordinate. It returns exactly one B response per accepted burst, and only after that burst's last W beat. They also assume that request addresses are word-aligned and beat counts are non-zero. The bench's responder model counts completed W bursts and raises B only in a later cycle than the last beat. All requests it sends use aligned addresses and counts of one or more. The payload stream is fed concurrently with, or after, the request, so the buffer never holds words that belong to no request.

// File: rtl/wba_pkg.sv
package wba_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam int         PAGE_BITS  = 12;
endpackage

// File: rtl/wba_fifo.sv
module wba_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [0:DEPTH-1];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/wba_splitter.sv
module wba_splitter #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int MAX_BURST = 16,
  parameter int SIZE_LOG  = 2,
  localparam int BL_W     = $clog2(MAX_BURST + 1),
  localparam int CW       = (LEN_W > 13) ? LEN_W : 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_beats,
  input  logic              take,
  output logic              active,
  output logic [ADDR_W-1:0] bst_addr,
  output logic [BL_W-1:0]   bst_len
);
  import wba_pkg::*;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              act_q, act_d;
  logic [CW-1:0]     room, rem_x, cap_x;

  // beats left before the next page boundary, and the burst size picked
  always_comb begin
    room  = (CW'(13'd4096) - CW'(addr_q[PAGE_BITS-1:0])) >> SIZE_LOG;
    rem_x = CW'(rem_q);
    cap_x = CW'(MAX_BURST);
    if (room < cap_x && room <= rem_x) bst_len = room[BL_W-1:0];
    else if (rem_x < cap_x)            bst_len = rem_q[BL_W-1:0];
    else                               bst_len = BL_W'(MAX_BURST);
  end

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    act_d  = act_q;
    if (load) begin
      addr_d = load_addr;
      rem_d  = load_beats;
      act_d  = (load_beats != '0);
    end else if (take) begin
      addr_d = addr_q + (ADDR_W'(bst_len) << SIZE_LOG);
      rem_d  = rem_q - LEN_W'(bst_len);
      act_d  = (rem_d != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      act_q  <= act_d;
    end
  end

  assign active   = act_q;
  assign bst_addr = addr_q;
endmodule

// File: rtl/wba_tracker.sv
module wba_tracker #(
  parameter int MAX_OUTST = 16,
  localparam int OW       = $clog2(MAX_OUTST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          aw_fire,
  input  logic          b_fire,
  input  logic          b_bad,
  input  logic          split_active,
  output logic [OW-1:0] outst,
  output logic          busy,
  output logic          done,
  output logic          done_err
);
  logic [OW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, err_q, err_d, done_q, done_d, fin;

  always_comb begin
    cnt_d  = cnt_q + OW'(aw_fire) - OW'(b_fire);
    fin    = busy_q && !split_active && (cnt_q == '0);
    busy_d = busy_q;
    if (start)    busy_d = 1'b1;
    else if (fin) busy_d = 1'b0;
    done_d = fin;
    err_d  = err_q;
    if (start)                err_d = 1'b0;
    else if (b_fire && b_bad) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign outst    = cnt_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign done_err = done_q & err_q;
endmodule

// File: rtl/wr_burst_adapter.sv
module wr_burst_adapter #(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int LEN_W        = 12,
  parameter int MAX_BURST    = 16,
  parameter int MAX_OUTST    = 16,
  parameter bit CONSERVATIVE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_beats,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  output logic                done_valid,
  output logic                done_err,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp
);
  import wba_pkg::*;

  localparam int BYTES     = DATA_W / 8;
  localparam int SIZE_LOG  = $clog2(BYTES);
  localparam int BL_W      = $clog2(MAX_BURST + 1);
  localparam int BUF_DEPTH = MAX_OUTST * MAX_BURST;
  localparam int CNT_W     = $clog2(BUF_DEPTH + 1);
  localparam int OW        = $clog2(MAX_OUTST + 1);

  logic              start, aw_fire, w_fire, in_fire, data_ok;
  logic              split_act, busy;
  logic [BL_W-1:0]   bst_len, lq_len;
  logic [OW-1:0]     outst_cnt, lq_cnt;
  logic [CNT_W-1:0]  d_cnt;
  logic [BL_W-1:0]   beat_q, beat_d;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;
  assign in_ready  = (d_cnt != CNT_W'(BUF_DEPTH));
  assign in_fire   = in_valid && in_ready;
  assign aw_fire   = m_awvalid && m_awready;
  assign w_fire    = m_wvalid && m_wready;

  wba_splitter #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .SIZE_LOG(SIZE_LOG)
  ) u_split (
    .clk(clk), .rst_n(rst_n), .load(start), .load_addr(req_addr),
    .load_beats(req_beats), .take(aw_fire), .active(split_act),
    .bst_addr(m_awaddr), .bst_len(bst_len)
  );

  wba_tracker #(.MAX_OUTST(MAX_OUTST)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start), .aw_fire(aw_fire),
    .b_fire(m_bvalid), .b_bad(m_bresp != RESP_OKAY), .split_active(split_act),
    .outst(outst_cnt), .busy(busy), .done(done_valid), .done_err(done_err)
  );

  // payload buffer sized for every burst that may be open at once
  wba_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_dbuf (
    .clk(clk), .rst_n(rst_n), .push(in_fire), .din(in_data),
    .pop(w_fire), .dout(m_wdata), .count(d_cnt)
  );

  // burst lengths in address-phase order, consumed by the W side
  wba_fifo #(.W(BL_W), .DEPTH(MAX_OUTST)) u_lenq (
    .clk(clk), .rst_n(rst_n), .push(aw_fire), .din(bst_len),
    .pop(w_fire && m_wlast), .dout(lq_len), .count(lq_cnt)
  );

  generate
    if (CONSERVATIVE) begin : g_safe
      logic [CNT_W-1:0] pend_q, pend_d;
      always_comb begin
        pend_d = pend_q;
        if (aw_fire) pend_d = pend_d + CNT_W'(bst_len);
        if (w_fire)  pend_d = pend_d - CNT_W'(1);
        data_ok = ((d_cnt - pend_q) >= CNT_W'(bst_len));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
      end
    end else begin : g_eager
      assign data_ok = 1'b1;
    end
  endgenerate

  assign m_awvalid = split_act && (outst_cnt != OW'(MAX_OUTST)) && data_ok;
  assign m_awlen   = 8'(bst_len - BL_W'(1));
  assign m_awsize  = 3'(SIZE_LOG);
  assign m_awburst = BURST_INCR;

  assign m_wvalid  = (lq_cnt != '0) && (d_cnt != '0);
  assign m_wlast   = (beat_q == lq_len - BL_W'(1));
  assign m_wstrb   = '1;
  assign m_bready  = 1'b1;

  always_comb begin
    beat_d = beat_q;
    if (w_fire) beat_d = m_wlast ? '0 : beat_q + BL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end
endmodule

// File: rtl/wba_checker.sv
module wba_checker #(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int MAX_BURST    = 16,
  parameter int MAX_OUTST    = 16,
  parameter bit CONSERVATIVE = 1'b0,
  localparam int OW          = $clog2(MAX_OUTST + 1),
  localparam int SIZE_LOG    = $clog2(DATA_W / 8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic [11:0]       awaddr_lo,
  input logic [7:0]        awlen,
  input logic              wvalid,
  input logic              wready,
  input logic [DATA_W-1:0] wdata,
  input logic              wlast,
  input logic [OW-1:0]     outst,
  input logic [OW-1:0]     lq_cnt,
  input logic              done_valid
);
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (32'(awlen) < MAX_BURST)); // R2

  AST_PAGE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> ((14'(awaddr_lo) + ((14'(awlen) + 14'd1) << SIZE_LOG)) <= 14'd4096)); // R3

  AST_OPEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= OW'(MAX_OUTST)); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (!awvalid && lq_cnt == '0)); // R8

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr_lo) && $stable(awlen))); // R10

  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast))); // R10

  generate
    if (CONSERVATIVE) begin : g_safe_chk
      AST_DATA_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_cnt != '0) |-> wvalid); // R6
    end
  endgenerate
endmodule

bind wr_burst_adapter wba_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST),
  .MAX_OUTST(MAX_OUTST), .CONSERVATIVE(CONSERVATIVE)
) u_wba_checker (
  .clk(clk), .rst_n(rst_n), .awvalid(m_awvalid), .awready(m_awready),
  .awaddr_lo(m_awaddr[11:0]), .awlen(m_awlen), .wvalid(m_wvalid),
  .wready(m_wready), .wdata(m_wdata), .wlast(m_wlast), .outst(outst_cnt),
  .lq_cnt(lq_cnt), .done_valid(done_valid)
);

// File: tb/test_wr_burst_adapter.sv
module test_wr_burst_adapter;
  localparam int AW = 32, DW = 32, LW = 12, MB = 4, MO = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  // eager instance signals
  logic req_valid, req_ready, in_valid, in_ready, done_valid, done_err;
  logic [AW-1:0] req_addr, awaddr;
  logic [LW-1:0] req_beats;
  logic [DW-1:0] in_data, wdata;
  logic awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic [7:0] awlen;
  logic [2:0] awsize;
  logic [1:0] awburst, bresp;
  logic [DW/8-1:0] wstrb;

  // conservative instance signals
  logic c_req_valid, c_req_ready, c_in_valid, c_in_ready, c_done_valid, c_done_err;
  logic [AW-1:0] c_req_addr, c_awaddr;
  logic [LW-1:0] c_req_beats;
  logic [DW-1:0] c_in_data, c_wdata;
  logic c_awvalid, c_wvalid, c_wlast, c_bvalid, c_bready;
  logic [7:0] c_awlen;
  logic [2:0] c_awsize;
  logic [1:0] c_awburst;
  logic [DW/8-1:0] c_wstrb;

  wr_burst_adapter #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .MAX_BURST(MB),
    .MAX_OUTST(MO), .CONSERVATIVE(1'b0)) i_wr_burst_adapter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .done_valid(done_valid),
    .done_err(done_err), .m_awvalid(awvalid), .m_awready(awready),
    .m_awaddr(awaddr), .m_awlen(awlen), .m_awsize(awsize), .m_awburst(awburst),
    .m_wvalid(wvalid), .m_wready(wready), .m_wdata(wdata), .m_wstrb(wstrb),
    .m_wlast(wlast), .m_bvalid(bvalid), .m_bready(bready), .m_bresp(bresp));

  wr_burst_adapter #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .MAX_BURST(MB),
    .MAX_OUTST(MO), .CONSERVATIVE(1'b1)) i_wr_burst_adapter_safe (
    .clk(clk), .rst_n(rst_n), .req_valid(c_req_valid), .req_ready(c_req_ready),
    .req_addr(c_req_addr), .req_beats(c_req_beats), .in_valid(c_in_valid),
    .in_ready(c_in_ready), .in_data(c_in_data), .done_valid(c_done_valid),
    .done_err(c_done_err), .m_awvalid(c_awvalid), .m_awready(1'b1),
    .m_awaddr(c_awaddr), .m_awlen(c_awlen), .m_awsize(c_awsize),
    .m_awburst(c_awburst), .m_wvalid(c_wvalid), .m_wready(1'b1),
    .m_wdata(c_wdata), .m_wstrb(c_wstrb), .m_wlast(c_wlast),
    .m_bvalid(c_bvalid), .m_bready(c_bready), .m_bresp(2'b00));

  int checks = 0, fails = 0;
  logic [AW-1:0] aw_addr_log [0:63];
  logic [7:0]    aw_len_log  [0:63];
  logic [DW-1:0] w_data_log  [0:127];
  logic          w_last_log  [0:127];
  int aw_n = 0, w_n = 0, bq = 0, b_idx = 0, err_at = -1, done_n = 0;
  int c_aw_n = 0, c_bq = 0, c_done_n = 0;
  bit b_hold = 1'b0, fmt_bad = 1'b0, done_err_last = 1'b0;

  // responder model: decides at the falling edge which handshakes the next rising edge completes
  always @(negedge clk) begin
    if (rst_n) begin
      if (awvalid && awready) begin
        aw_addr_log[aw_n] = awaddr;
        aw_len_log[aw_n]  = awlen;
        if (awburst != 2'b01 || awsize != 3'd2) fmt_bad = 1'b1;
        aw_n++;
      end
      if (bvalid && bready) begin bq--; b_idx++; end
      bvalid = !b_hold && (bq > 0);
      bresp  = (b_idx == err_at) ? 2'b10 : 2'b00;
      if (wvalid && wready) begin
        w_data_log[w_n] = wdata;
        w_last_log[w_n] = wlast;
        w_n++;
        if (wlast) bq++;
      end
      if (done_valid) begin done_n++; done_err_last = done_err; end
      if (c_awvalid) c_aw_n++;
      if (c_bvalid && c_bready) c_bq--;
      c_bvalid = (c_bq > 0);
      if (c_wvalid && c_wlast) c_bq++;
      if (c_done_valid) c_done_n++;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [AW-1:0] a, input int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_beats = LW'(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic feed(input int n, input logic [DW-1:0] base);
    int i = 0;
    bit acc;
    @(negedge clk);
    while (i < n) begin
      in_valid = 1'b1; in_data = base + DW'(i);
      acc = in_ready;
      @(negedge clk);
      if (acc) i++;
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    int t = 0;
    while (done_n == prev && t < 500) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 awvalid", awvalid, 0);
    chk("R1 wvalid", wvalid, 0);
    chk("R1 done_valid", done_valid, 0);
    chk("R1 req_ready/in_ready", {req_ready, in_ready}, 2'b11);
  endtask

  task automatic t_split();
    int a0 = aw_n, w0 = w_n, d0 = done_n, bad = 0;
    fork send_req(32'h100, 10); feed(10, 32'hA000); join
    wait_done(d0);
    chk("R2 burst count", aw_n - a0, 3);
    chk("R2 addresses", {aw_addr_log[a0], aw_addr_log[a0+1], aw_addr_log[a0+2]},
        {32'h100, 32'h110, 32'h120});
    chk("R2 lengths", {aw_len_log[a0], aw_len_log[a0+1], aw_len_log[a0+2]}, 24'h030301);
    chk("R2 burst type and size", fmt_bad, 0);
    for (int i = 0; i < 10; i++) begin
      if (w_data_log[w0+i] != 32'hA000 + 32'(i)) bad++;
      if (w_last_log[w0+i] != (i == 3 || i == 7 || i == 9)) bad++;
    end
    chk("R4 data order and last flags", bad, 0);
    chk("R8 one completion", done_n - d0, 1);
  endtask

  task automatic t_page();
    int a0 = aw_n, w0 = w_n, d0 = done_n;
    fork send_req(32'hFF8, 6); feed(6, 32'hC000); join
    wait_done(d0);
    chk("R3 page split count", aw_n - a0, 2);
    chk("R3 page split addrs", {aw_addr_log[a0], aw_addr_log[a0+1]}, {32'hFF8, 32'h1000});
    chk("R3 page split lens", {aw_len_log[a0], aw_len_log[a0+1]}, 16'h0103);
    chk("R4 last at page split", {w_last_log[w0+1], w_last_log[w0+5], w_last_log[w0+2]}, 3'b110);
  endtask

  task automatic t_outst();
    int a0 = aw_n, d0 = done_n;
    b_hold = 1'b1;
    fork send_req(32'h2000, 12); feed(12, 32'hB000); join
    repeat (30) @(negedge clk);
    chk("R5 open burst limit", aw_n - a0, 2);
    chk("R8 no completion while open", done_n - d0, 0);
    b_hold = 1'b0;
    wait_done(d0);
    chk("R5 resumes after B", aw_n - a0, 3);
  endtask

  task automatic t_error();
    int d0 = done_n;
    err_at = b_idx + 1;
    fork send_req(32'h3000, 8); feed(8, 32'hD000); join
    wait_done(d0);
    chk("R9 error reported", done_err_last, 1);
    err_at = -1;
    d0 = done_n;
    fork send_req(32'h3100, 4); feed(4, 32'hD100); join
    wait_done(d0);
    chk("R9 error cleared", done_err_last, 0);
  endtask

  task automatic t_eager();
    int a0 = aw_n, d0 = done_n;
    send_req(32'h4000, 4);
    repeat (4) @(negedge clk);
    chk("R7 address before data", aw_n - a0, 1);
    chk("R8 busy blocks requests", req_ready, 0);
    feed(4, 32'hE000);
    wait_done(d0);
    chk("R8 ready after completion", req_ready, 1);
  endtask

  task automatic t_hold();
    int d0 = done_n;
    awready = 1'b0;
    send_req(32'h5000, 4);
    repeat (3) @(negedge clk);
    chk("R10 awvalid held", awvalid, 1);
    repeat (3) @(negedge clk);
    chk("R10 payload stable", {awvalid, awaddr, awlen}, {1'b1, 32'h5000, 8'h03});
    awready = 1'b1;
    feed(4, 32'hF000);
    wait_done(d0);
  endtask

  task automatic t_safe();
    int t = 0;
    @(negedge clk);
    c_req_valid = 1'b1; c_req_addr = 32'h600; c_req_beats = LW'(4);
    @(negedge clk);
    c_req_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk("R6 no address without data", {c_aw_n[7:0], 7'd0, c_awvalid}, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      c_in_valid = 1'b1; c_in_data = 32'h60 + 32'(i);
      @(negedge clk);
    end
    c_in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 partial data holds address", c_aw_n, 0);
    c_in_valid = 1'b1; c_in_data = 32'h63;
    @(negedge clk);
    c_in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 address after full burst", c_aw_n, 1);
    while (c_done_n == 0 && t < 200) begin @(negedge clk); t++; end
    chk("R6 request completes", c_done_n, 1);
  endtask

  initial begin
    req_valid = 0; req_addr = '0; req_beats = '0; in_valid = 0; in_data = '0;
    awready = 1'b1; wready = 1'b1; bvalid = 1'b0; bresp = 2'b00;
    c_req_valid = 0; c_req_addr = '0; c_req_beats = '0; c_in_valid = 0;
    c_in_data = '0; c_bvalid = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_split();
    t_page();
    t_outst();
    t_error();
    t_eager();
    t_hold();
    t_safe();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule